// File: doc/BRIEF.md
# USB Interrupt Status Aggregator

This block collects the interrupt sources of a USB device controller into one read-only status byte on a small 8-bit I/O port bus. The five status bits are active low: each reads 1 while its source is quiet and drops to 0 while an event of that kind is pending. The idle value is therefore 1Fh, and the three upper bits always read 0. A single `irq` output is raised while any of the five bits is low.

Writing the status port does nothing. Each pending bit is cleared through a different route. Four USB line inputs pass through a synchronizer and then an edge detector. Rise and fall detection is enabled per line. A flag register shows which lines changed, and a write-one-to-clear control register acknowledges the line flags, the overrun flag and the unknown-event flag. Protocol events are acknowledged by reading any of the protocol event addresses. Suspend is acknowledged by writing zero to the protocol enable register.

Default address map: status 10h, line change flags 11h, line enable 12h, line control 13h, protocol enable 14h, protocol event registers 18h to 1Bh. Reads of the line control register, of the event registers and of unmapped addresses return 00h. Read data is combinational from `addr` while `rdEn` is high. Writes take effect on the clock edge.

Top module: `usb_irq_status`

## Requirements
- R1: Reading the status address returns 1Fh while nothing is pending. Bits 7 to 5 of the status port always read 0.
- R2: A write to the status address changes neither the status value nor `irq`.
- R3: The suspend bit (bit 0) goes low on a `suspendPulse` while bit 1 of the protocol enable register is 1. A pulse is ignored while that bit is 0. Writing 00h to the protocol enable register clears the pending suspend, and the register reads back its stored value.
- R4: Each line input passes through two synchronizer flops. In the line enable register, bit n enables rising edges of line n and bit n+4 enables falling edges of line n. An enabled edge sets bit n of the line flag register and drives status bit 2 low on the third rising clock edge after the input changes. A disabled edge sets nothing.
- R5: Writing the line control register with bit 0 = 1 clears all line flags, and status bit 2 returns to 1.
- R6: An `overrunPulse` drives status bit 3 low. Writing the line control register with bit 2 = 1 clears it.
- R7: A `protoEventPulse` drives status bit 4 low only while bit 0 of the protocol enable register is 1. A read of any protocol event address clears it.
- R8: An `unknownPulse` drives status bit 1 low. Writing the line control register with bit 1 = 1 clears it.
- R9: `irq` is 1 exactly when at least one of status bits 4 to 0 is 0.
- R10: Reset clears every pending flag and register, so the status reads 1Fh, `irq` is 0, and the enable registers read 00h.
- R11: When an event and its acknowledge arrive in the same cycle, the event wins and the bit stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Port address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe; reads of event addresses acknowledge |
| rdData | output | 8 | Read data, 00h when rdEn is low |
| lineIn | input | 4 | Asynchronous USB line levels |
| suspendPulse | input | 1 | Bus suspend event |
| overrunPulse | input | 1 | Missed incoming byte |
| protoEventPulse | input | 1 | Device-level event or transaction completion |
| unknownPulse | input | 1 | Unclassified event |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets edges that are disabled: rising on a line armed only for falling, and the reverse. A design that merged the rise and fall enables would raise a flag there. Protocol and suspend pulses that arrive while their enable bit is clear must leave the status at 1Fh; a design that latches them regardless would drop the bit. The bench drives an event in the same cycle as its acknowledge to catch a clear that takes priority. It also writes FFh to the status port, which a writable status port would corrupt. It resets the block in the middle of activity to expose flags that survive reset.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  typedef struct packed {
    logic wrLineEn;
    logic wrLineCtrl;
    logic wrProtoEn;
    logic rdProtoEvt;
  } strobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_FLAGS,
    SEL_LINEEN,
    SEL_PROTOEN
  } rdsel_t;
endpackage

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] LINEEN_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] LINECTRL_ADDR = 8'h13,
  parameter logic [ADDR_W-1:0] PROTOEN_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] EVT_BASE = 8'h18,
  parameter int EVT_COUNT = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           strobes,
  output rdsel_t            rdSel
);
  localparam logic [ADDR_W:0] EVT_END = {1'b0, EVT_BASE} + (ADDR_W+1)'(EVT_COUNT);

  logic inEvtRange;
  assign inEvtRange = ({1'b0, addr} >= {1'b0, EVT_BASE}) && ({1'b0, addr} < EVT_END);

  always_comb begin
    strobes.wrLineEn   = wrEn && (addr == LINEEN_ADDR);
    strobes.wrLineCtrl = wrEn && (addr == LINECTRL_ADDR);
    strobes.wrProtoEn  = wrEn && (addr == PROTOEN_ADDR);
    strobes.rdProtoEvt = rdEn && inEvtRange;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (rdEn) begin
      if (addr == STATUS_ADDR)       rdSel = SEL_STATUS;
      else if (addr == FLAGS_ADDR)   rdSel = SEL_FLAGS;
      else if (addr == LINEEN_ADDR)  rdSel = SEL_LINEEN;
      else if (addr == PROTOEN_ADDR) rdSel = SEL_PROTOEN;
    end
  end
endmodule

// File: rtl/usb_irq_datapath.sv
module usb_irq_datapath
  import usb_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  rdsel_t               rdSel,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 suspendPulse,
  input  logic                 overrunPulse,
  input  logic                 protoEventPulse,
  input  logic                 unknownPulse,
  output logic [DATA_W-1:0]    rdData,
  output logic [4:0]           statusBits,
  output logic [1:0]           protoEnQ,
  output logic                 irq
);
  localparam int EN_W = 2 * NUM_LINES;

  logic [NUM_LINES-1:0] syncA, syncB, prevQ, edgeHit, lineFlags;
  logic [EN_W-1:0] lineEnQ;
  logic suspendPend, unknownPend, overrunPend, protoPend;
  logic ackLines, ackUnknown, ackOverrun, ackSuspend;

  assign ackLines   = strobes.wrLineCtrl && wrData[0];
  assign ackUnknown = strobes.wrLineCtrl && wrData[1];
  assign ackOverrun = strobes.wrLineCtrl && wrData[2];
  assign ackSuspend = strobes.wrProtoEn && (wrData == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic rise, fall;
    assign rise = syncB[i] && !prevQ[i] && lineEnQ[i];
    assign fall = !syncB[i] && prevQ[i] && lineEnQ[i+NUM_LINES];
    assign edgeHit[i] = rise || fall;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           lineFlags[i] <= 1'b0;
      else if (edgeHit[i]) lineFlags[i] <= 1'b1;
      else if (ackLines)   lineFlags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineEnQ <= '0;
      protoEnQ <= '0;
    end else begin
      if (strobes.wrLineEn)  lineEnQ <= wrData[EN_W-1:0];
      if (strobes.wrProtoEn) protoEnQ <= wrData[1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspendPend <= 1'b0;
      unknownPend <= 1'b0;
      overrunPend <= 1'b0;
      protoPend   <= 1'b0;
    end else begin
      if (suspendPulse && protoEnQ[1]) suspendPend <= 1'b1;
      else if (ackSuspend)             suspendPend <= 1'b0;

      if (unknownPulse)    unknownPend <= 1'b1;
      else if (ackUnknown) unknownPend <= 1'b0;

      if (overrunPulse)    overrunPend <= 1'b1;
      else if (ackOverrun) overrunPend <= 1'b0;

      if (protoEventPulse && protoEnQ[0]) protoPend <= 1'b1;
      else if (strobes.rdProtoEvt)        protoPend <= 1'b0;
    end
  end

  assign statusBits = ~{protoPend, overrunPend, |lineFlags, unknownPend, suspendPend};
  assign irq = ~&statusBits;

  always_comb begin
    unique case (rdSel)
      SEL_STATUS:  rdData = {{(DATA_W-5){1'b0}}, statusBits};
      SEL_FLAGS:   rdData = {{(DATA_W-NUM_LINES){1'b0}}, lineFlags};
      SEL_LINEEN:  rdData = {{(DATA_W-EN_W){1'b0}}, lineEnQ};
      SEL_PROTOEN: rdData = {{(DATA_W-2){1'b0}}, protoEnQ};
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NUM_LINES = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] LINEEN_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] LINECTRL_ADDR = 8'h13,
  parameter logic [ADDR_W-1:0] PROTOEN_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] EVT_BASE = 8'h18,
  parameter int EVT_COUNT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEn,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 suspendPulse,
  input  logic                 overrunPulse,
  input  logic                 protoEventPulse,
  input  logic                 unknownPulse,
  output logic                 irq
);
  strobe_t strobes;
  rdsel_t rdSel;
  logic [4:0] statusBits;
  logic [1:0] protoEnQ;

  usb_irq_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .FLAGS_ADDR(FLAGS_ADDR),
    .LINEEN_ADDR(LINEEN_ADDR), .LINECTRL_ADDR(LINECTRL_ADDR),
    .PROTOEN_ADDR(PROTOEN_ADDR), .EVT_BASE(EVT_BASE), .EVT_COUNT(EVT_COUNT)
  ) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .strobes(strobes), .rdSel(rdSel)
  );

  usb_irq_datapath #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel), .wrData(wrData),
    .lineIn(lineIn), .suspendPulse(suspendPulse), .overrunPulse(overrunPulse),
    .protoEventPulse(protoEventPulse), .unknownPulse(unknownPulse),
    .rdData(rdData), .statusBits(statusBits), .protoEnQ(protoEnQ), .irq(irq)
  );
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] PROTOEN_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] EVT_BASE = 8'h18,
  parameter int EVT_COUNT = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              suspendPulse,
  input logic              overrunPulse,
  input logic              protoEventPulse,
  input logic              unknownPulse,
  input logic [4:0]        statusBits,
  input logic [1:0]        protoEnQ,
  input logic              irq
);
  logic stRead, evtRead;
  assign stRead = rdEn && (addr == STATUS_ADDR);
  assign evtRead = rdEn && ({1'b0, addr} >= {1'b0, EVT_BASE}) &&
                   ({1'b0, addr} < ({1'b0, EVT_BASE} + (ADDR_W+1)'(EVT_COUNT)));

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    stRead |-> rdData[DATA_W-1:5] == '0);

  p_irq_from_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    stRead |-> irq == (rdData[4:0] != 5'h1F));

  p_suspend_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (suspendPulse && protoEnQ[1]) |=> !statusBits[0]);

  p_suspend_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == PROTOEN_ADDR && wrData == '0 && !suspendPulse) |=> statusBits[0]);

  p_proto_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (evtRead && !protoEventPulse) |=> statusBits[4]);

  p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |=> !statusBits[3]);

  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    unknownPulse |=> !statusBits[1]);
endmodule

bind usb_irq_status usb_irq_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR),
  .PROTOEN_ADDR(PROTOEN_ADDR), .EVT_BASE(EVT_BASE), .EVT_COUNT(EVT_COUNT)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdEn(rdEn), .rdData(rdData), .suspendPulse(suspendPulse),
  .overrunPulse(overrunPulse), .protoEventPulse(protoEventPulse),
  .unknownPulse(unknownPulse), .statusBits(statusBits), .protoEnQ(protoEnQ),
  .irq(irq)
);

// File: tb/tb_usb_irq_status.sv
module tb_usb_irq_status;
  localparam logic [7:0] ST  = 8'h10;
  localparam logic [7:0] FLG = 8'h11;
  localparam logic [7:0] LEN = 8'h12;
  localparam logic [7:0] LCT = 8'h13;
  localparam logic [7:0] PEN = 8'h14;
  localparam logic [7:0] EVT = 8'h1A;

  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OP = 2'd2, OL = 2'd3;
  localparam int N = 45;

  // {op, addr, data, expected, requirement}; pulse data: bit0 suspend,
  // bit1 overrun, bit2 protocol, bit3 unknown
  localparam logic [29:0] VEC [N] = '{
    {OR, ST,  8'h00, 8'h1F, 4'd1},   // R1 idle
    {OR, LEN, 8'h00, 8'h00, 4'd10},  // R10
    {OR, PEN, 8'h00, 8'h00, 4'd10},  // R10
    {OW, ST,  8'hFF, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h1F, 4'd2},   // R2 status write ignored
    {OW, LEN, 8'h01, 8'h00, 4'd0},
    {OL, 8'h00, 8'h01, 8'h00, 4'd0},
    {OR, FLG, 8'h00, 8'h01, 4'd4},   // R4 enabled rise
    {OR, ST,  8'h00, 8'h1B, 4'd4},
    {OL, 8'h00, 8'h00, 8'h00, 4'd0},
    {OR, FLG, 8'h00, 8'h01, 4'd4},   // R4 disabled fall
    {OW, LCT, 8'h01, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h1F, 4'd5},   // R5
    {OR, FLG, 8'h00, 8'h00, 4'd5},
    {OW, LEN, 8'h80, 8'h00, 4'd0},
    {OL, 8'h00, 8'h08, 8'h00, 4'd0},
    {OR, FLG, 8'h00, 8'h00, 4'd4},   // R4 disabled rise
    {OL, 8'h00, 8'h00, 8'h00, 4'd0},
    {OR, FLG, 8'h00, 8'h08, 4'd4},   // R4 enabled fall
    {OR, ST,  8'h00, 8'h1B, 4'd4},
    {OW, LCT, 8'h01, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h1F, 4'd5},   // R5
    {OP, 8'h00, 8'h08, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h1D, 4'd8},   // R8
    {OW, LCT, 8'h02, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h1F, 4'd8},
    {OP, 8'h00, 8'h02, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h17, 4'd6},   // R6
    {OW, LCT, 8'h04, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h1F, 4'd6},
    {OP, 8'h00, 8'h04, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h1F, 4'd7},   // R7 disabled
    {OW, PEN, 8'h01, 8'h00, 4'd0},
    {OP, 8'h00, 8'h04, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h0F, 4'd7},   // R7 enabled
    {OR, EVT, 8'h00, 8'h00, 4'd7},
    {OR, ST,  8'h00, 8'h1F, 4'd7},   // R7 read acknowledge
    {OP, 8'h00, 8'h01, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h1F, 4'd3},   // R3 disabled
    {OW, PEN, 8'h03, 8'h00, 4'd0},
    {OP, 8'h00, 8'h01, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h1E, 4'd3},   // R3
    {OR, PEN, 8'h00, 8'h03, 4'd3},
    {OW, PEN, 8'h00, 8'h00, 4'd0},
    {OR, ST,  8'h00, 8'h1F, 4'd3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] addr = '0, wrData = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] rdData;
  logic [3:0] lineIn = '0;
  logic suspendPulse = 1'b0, overrunPulse = 1'b0, protoEventPulse = 1'b0, unknownPulse = 1'b0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_irq_status dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .lineIn(lineIn), .suspendPulse(suspendPulse),
    .overrunPulse(overrunPulse), .protoEventPulse(protoEventPulse),
    .unknownPulse(unknownPulse), .irq(irq)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [7:0] exp, input int req);
    addr = a; rdEn = 1'b1;
    #1 check(rdData, exp, req, "read");
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doPulse(input logic [3:0] sel);
    {unknownPulse, protoEventPulse, overrunPulse, suspendPulse} = sel;
    @(posedge clk); @(negedge clk);
    {unknownPulse, protoEventPulse, overrunPulse, suspendPulse} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({7'd0, irq}, 8'h00, 10, "irq in reset");  // R10
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      logic [29:0] v;
      v = VEC[i];
      case (v[29:28])
        OW: doWrite(v[27:20], v[19:12]);
        OR: doRead(v[27:20], v[11:4], int'(v[3:0]));
        OP: doPulse(v[15:12]);
        default: begin
          lineIn = v[15:12];
          repeat (3) @(posedge clk);
          @(negedge clk);
        end
      endcase
    end

    // R9: several sources at once, then irq drops after all acknowledges
    doWrite(PEN, 8'h03);
    doPulse(4'hF);
    doRead(ST, 8'h04, 9);
    check({7'd0, irq}, 8'h01, 9, "irq with pending");
    doWrite(LCT, 8'h06);
    doRead(EVT, 8'h00, 9);
    doWrite(PEN, 8'h00);
    doRead(ST, 8'h1F, 9);
    check({7'd0, irq}, 8'h00, 9, "irq idle");

    // R11: event and acknowledge together
    unknownPulse = 1'b1;
    doWrite(LCT, 8'h02);
    unknownPulse = 1'b0;
    doRead(ST, 8'h1D, 11);
    doWrite(LCT, 8'h02);
    doWrite(PEN, 8'h01);
    protoEventPulse = 1'b1;
    doRead(EVT, 8'h00, 11);
    protoEventPulse = 1'b0;
    doRead(ST, 8'h0F, 11);

    // R10: reset in the middle of activity
    doPulse(4'h2);
    rstN = 1'b0;
    @(negedge clk);
    check({7'd0, irq}, 8'h00, 10, "irq after reset");
    rstN = 1'b1;
    @(negedge clk);
    doRead(ST, 8'h1F, 10);
    doRead(PEN, 8'h00, 10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule